// File: doc/BRIEF.md
# Four-Channel Scaled PWM Timer

This peripheral holds one free-running 31-bit counter and four 16-bit compare channels. A 4-bit scale field picks which 16-bit slice of the counter is used as the scaled count. Every clock, each channel compares the scaled count against its own compare value. When the scaled count is greater than or equal to that value, the channel's pending flag is set on the next clock and drives its interrupt line. The flag stays set until software clears it.

The counter runs either continuously or in one-shot mode. One-shot enable clears itself when the counter restarts or wraps. With the restart option set, a channel 0 match sends the counter back to zero. This makes channel 0 the period register for the other channels.

Software uses a single-cycle bus: a valid strobe, a write flag, an address, write data, and combinational read data.

The run control is a four-state machine driven by the two enable bits:
- MODE_HALT: counter holds.
- MODE_FREE: continuous enable only.
- MODE_SINGLE: one-shot enable only.
- MODE_BOTH: both enables set.

Its transitions are:
- T_CFG: any state goes to the state encoded by a configuration write.
- T_DROP_SINGLE: MODE_SINGLE goes to MODE_HALT on a restart or carry event.
- T_DROP_BOTH: MODE_BOTH goes to MODE_FREE on the same events.
- T_STAY: every other cycle keeps the current state.

Top module: `pwm4_timer`

## Requirements
- R1: After reset, these registers all read zero:
  - configuration (offset 0x00),
  - counter (0x08),
  - scaled count (0x10),
  - the four compare registers (0x20, 0x24, 0x28, 0x2C).

  All interrupt lines are low until the first clock edge after reset.
- R2: The counter advances by one each clock while configuration bit 12 (continuous) or bit 13 (one-shot) is set. Otherwise it holds its value.
- R3: Reads of 0x10 return counter bits [scale+15:scale], zero-filled above bit 30, where scale is configuration bits 3:0. Reads of 0x08 return the counter with bit 31 always 0.
- R4: A compare register keeps only the low 16 bits of a write, and reads back zero-extended.
- R5: Channel i's pending flag (configuration bit 28+i) and irq[i] are set one clock after the scaled count is greater than or equal to compare i. They then stay set.
- R6: A configuration write sets each pending flag to the written bit 28+i. Writing 0 drops irq[i] on the next clock, which is re-raised one clock later if the match still holds.
- R7: With configuration bit 9 set, a channel 0 match sends the counter to 0 on the next clock and clears bit 13, unless the same cycle loads the counter.
- R8: When the running counter wraps from 0x7FFFFFFF to 0, bit 13 is cleared. Bit 12 is kept, so a continuous counter keeps running.
- R9: Writing 0x08 loads the counter with write data bits 30:0. Writing 0x10 loads it with (data & 0xFFFF) << scale, truncated to 31 bits. A load takes priority over restart and increment.
- R10: Unmapped offsets read 0, and writes to them change nothing. Configuration bits 8, 10, 19:16 and 27:24 are stored and read back but have no effect. Bits 7:4, 11, 15:14 and 23:20 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Single-cycle access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
Errors in the counter or the run-state machine show up within one clock in the counter and configuration read-back. They show up on irq as soon as the scaled count crosses a compare value. This is because each line is a registered image of a comparison made on the current count.

A wrong scale slice or load shift gives a wrong scaled-count read at once. It also moves each irq rising edge by a predictable number of clocks.

A one-shot bit that fails to clear on restart or wrap leaves the counter moving after the event. The next counter read exposes this.

The bench model steps alongside the design and compares irq on every clock and every read value.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    // Register offsets decoded by the bus
    localparam logic [7:0] OFS_CFG    = 8'h00;
    localparam logic [7:0] OFS_COUNT  = 8'h08;
    localparam logic [7:0] OFS_SCALED = 8'h10;
    localparam logic [7:0] OFS_CMP0   = 8'h20;
    localparam int         CMP_STRIDE = 4;

    // Configuration layout (fixed, four channels)
    localparam int NUM_CH      = 4;
    localparam int BIT_ZCMP    = 9;
    localparam int BIT_ALWAYS  = 12;
    localparam int BIT_ONESHOT = 13;
    localparam int IP_LSB      = 28;
    localparam logic [31:0] CFG_STORE_MASK = 32'h0F0F_070F;

    typedef enum logic [1:0] {
        MODE_HALT   = 2'd0,
        MODE_FREE   = 2'd1,
        MODE_SINGLE = 2'd2,
        MODE_BOTH   = 2'd3
    } mode_e;

endpackage

// File: rtl/pwm4_mode_fsm.sv
module pwm4_mode_fsm
    import pwm4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic wr_always,
    input  logic wr_oneshot,
    input  logic oneshot_clr,
    output logic run,
    output logic en_always,
    output logic en_oneshot
);

    mode_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            state_d = mode_e'({wr_oneshot, wr_always});          // T_CFG
        end else begin
            unique case (state_q)
                MODE_SINGLE: if (oneshot_clr) state_d = MODE_HALT; // T_DROP_SINGLE
                MODE_BOTH:   if (oneshot_clr) state_d = MODE_FREE; // T_DROP_BOTH
                MODE_HALT:   state_d = MODE_HALT;                  // T_STAY
                MODE_FREE:   state_d = MODE_FREE;                  // T_STAY
                default:     state_d = MODE_HALT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_HALT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        en_always  = 1'b0;
        en_oneshot = 1'b0;
        unique case (state_q)
            MODE_HALT:   ;
            MODE_FREE:   en_always = 1'b1;
            MODE_SINGLE: en_oneshot = 1'b1;
            MODE_BOTH: begin
                en_always  = 1'b1;
                en_oneshot = 1'b1;
            end
            default: ;
        endcase
        run = en_always | en_oneshot;
    end

    AST_ONESHOT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot_clr && !cfg_wr |=> !en_oneshot); // R8
    AST_ALWAYS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        en_always && !cfg_wr |=> en_always); // R8

endmodule

// File: rtl/pwm4_counter.sv
module pwm4_counter #(
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               restart,
    input  logic [SCALE_W-1:0] scale,
    output logic [CNT_W-1:0]   cnt,
    output logic [CMP_W-1:0]   scaled,
    output logic               carry
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load)    cnt_q <= load_val;
        else if (restart) cnt_q <= '0;
        else if (run)     cnt_q <= cnt_q + 1'b1;
    end

    // Window of CMP_W bits starting at bit position 'scale'
    always_comb begin
        for (int b = 0; b < CMP_W; b++) begin
            if (b + int'(scale) < CNT_W) scaled[b] = cnt_q[b + int'(scale)];
            else                         scaled[b] = 1'b0;
        end
    end

    assign cnt   = cnt_q;
    assign carry = run && !load && !restart && (cnt_q == CNT_MAX);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load && !restart |=> $stable(cnt_q)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !load && !restart && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1); // R2
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart && !load |=> cnt_q == '0); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val)); // R9

endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr,
    input  logic [CMP_W-1:0] cmp_wdata,
    input  logic [CMP_W-1:0] scaled,
    input  logic             ip_wr,
    input  logic             ip_wdata,
    output logic [CMP_W-1:0] cmp,
    output logic             hit,
    output logic             ip
);

    logic [CMP_W-1:0] cmp_q;
    logic             ip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= cmp_wdata;
    end

    assign hit = (scaled >= cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ip_q <= 1'b0;
        else if (ip_wr) ip_q <= ip_wdata;
        else if (hit)   ip_q <= 1'b1;
    end

    assign cmp = cmp_q;
    assign ip  = ip_q;

    AST_IP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !ip_wr |=> ip_q); // R5
    AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ip_q && !ip_wr |=> ip_q); // R5
    AST_IP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ip_wr |=> ip_q == $past(ip_wdata)); // R6

endmodule

// File: rtl/pwm4_timer.sv
module pwm4_timer
    import pwm4_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 31,
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int NCH = NUM_CH;

    logic                 wr, rd_cfg, rd_cnt, rd_scl;
    logic                 wr_cfg, wr_cnt, wr_scl;
    logic [NCH-1:0]       sel_cmp, wr_cmp;
    logic [DATA_W-1:0]    misc_q;
    logic [SCALE_W-1:0]   scale;
    logic                 zcmp;
    logic                 run, en_always, en_oneshot;
    logic                 load, restart, carry, oneshot_clr;
    logic [CNT_W-1:0]     load_val, cnt;
    logic [CMP_W-1:0]     scaled;
    logic [NCH-1:0]       hit, ip;
    logic [CMP_W-1:0]     cmp [NCH];

    // Address decode
    assign wr     = bus_valid && bus_write;
    assign rd_cfg = (bus_addr == ADDR_W'(OFS_CFG));
    assign rd_cnt = (bus_addr == ADDR_W'(OFS_COUNT));
    assign rd_scl = (bus_addr == ADDR_W'(OFS_SCALED));
    assign wr_cfg = wr && rd_cfg;
    assign wr_cnt = wr && rd_cnt;
    assign wr_scl = wr && rd_scl;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_sel
            assign sel_cmp[g] = (bus_addr == ADDR_W'(OFS_CMP0 + g * CMP_STRIDE));
            assign wr_cmp[g]  = wr && sel_cmp[g];
        end
    endgenerate

    // Stored configuration bits without run-control or pending effect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      misc_q <= '0;
        else if (wr_cfg) misc_q <= bus_wdata & CFG_STORE_MASK;
    end

    assign scale = misc_q[SCALE_W-1:0];
    assign zcmp  = misc_q[BIT_ZCMP];

    // Counter load value
    always_comb begin
        for (int b = 0; b < CNT_W; b++) begin
            if (wr_cnt) begin
                load_val[b] = bus_wdata[b];
            end else if (b >= int'(scale) && b - int'(scale) < CMP_W) begin
                load_val[b] = bus_wdata[b - int'(scale)];
            end else begin
                load_val[b] = 1'b0;
            end
        end
    end

    assign load        = wr_cnt || wr_scl;
    assign restart     = zcmp && hit[0];
    assign oneshot_clr = (restart && !load) || carry;

    pwm4_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (wr_cfg),
        .wr_always  (bus_wdata[BIT_ALWAYS]),
        .wr_oneshot (bus_wdata[BIT_ONESHOT]),
        .oneshot_clr(oneshot_clr),
        .run        (run),
        .en_always  (en_always),
        .en_oneshot (en_oneshot)
    );

    pwm4_counter #(
        .CNT_W  (CNT_W),
        .CMP_W  (CMP_W),
        .SCALE_W(SCALE_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .load    (load),
        .load_val(load_val),
        .restart (restart),
        .scale   (scale),
        .cnt     (cnt),
        .scaled  (scaled),
        .carry   (carry)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            pwm4_chan #(.CMP_W(CMP_W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .cmp_wr   (wr_cmp[g]),
                .cmp_wdata(bus_wdata[CMP_W-1:0]),
                .scaled   (scaled),
                .ip_wr    (wr_cfg),
                .ip_wdata (bus_wdata[IP_LSB + g]),
                .cmp      (cmp[g]),
                .hit      (hit[g]),
                .ip       (ip[g])
            );
        end
    endgenerate

    assign irq = ip;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (rd_cfg) begin
            bus_rdata = misc_q;
            bus_rdata[BIT_ALWAYS]  = en_always;
            bus_rdata[BIT_ONESHOT] = en_oneshot;
            bus_rdata[IP_LSB +: NCH] = ip;
        end else if (rd_cnt) begin
            bus_rdata[CNT_W-1:0] = cnt;
        end else if (rd_scl) begin
            bus_rdata[CMP_W-1:0] = scaled;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (sel_cmp[c]) bus_rdata[CMP_W-1:0] = cmp[c];
            end
        end
    end

    AST_RESTART_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        zcmp && hit[0] && !load && !wr_cfg |=> !en_oneshot && cnt == '0); // R7

endmodule

// File: tb/test_pwm4_timer.sv
module test_pwm4_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwm4_timer i_pwm4_timer (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Behavioural reference model
    longint m_cnt;
    longint m_cmp [4];
    bit     m_ip [4];
    longint m_misc;
    bit     m_always, m_oneshot;
    localparam longint CMAX = 64'h7FFF_FFFF;

    function automatic longint m_scaled();
        return (m_cnt >> (m_misc & 15)) & 64'hFFFF;
    endfunction

    function automatic longint m_read(input logic [7:0] a);
        longint r;
        r = 0;
        case (a)
            8'h00: begin
                r = m_misc | (longint'(m_always) << 12) | (longint'(m_oneshot) << 13);
                for (int i = 0; i < 4; i++) r = r | (longint'(m_ip[i]) << (28 + i));
            end
            8'h08: r = m_cnt;
            8'h10: r = m_scaled();
            8'h20: r = m_cmp[0];
            8'h24: r = m_cmp[1];
            8'h28: r = m_cmp[2];
            8'h2C: r = m_cmp[3];
            default: r = 0;
        endcase
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_misc = 0; m_always = 0; m_oneshot = 0;
            for (int i = 0; i < 4; i++) begin m_cmp[i] = 0; m_ip[i] = 0; end
        end else begin
            longint sc, d, nc;
            bit hits [4];
            bit w, ld, rs, cy, run, cw;
            sc  = m_scaled();
            d   = longint'(bus_wdata);
            w   = bus_valid && bus_write;
            for (int i = 0; i < 4; i++) hits[i] = (sc >= m_cmp[i]);
            run = m_always || m_oneshot;
            ld  = w && (bus_addr == 8'h08 || bus_addr == 8'h10);
            rs  = ((m_misc >> 9) & 1) == 1 && hits[0] && !ld;
            cy  = run && !ld && !rs && m_cnt == CMAX;
            cw  = w && bus_addr == 8'h00;
            if (ld && bus_addr == 8'h08) nc = d & CMAX;
            else if (ld) nc = ((d & 64'hFFFF) << (m_misc & 15)) & CMAX;
            else if (rs) nc = 0;
            else if (run) nc = (m_cnt + 1) & CMAX;
            else nc = m_cnt;
            for (int i = 0; i < 4; i++) begin
                if (cw) m_ip[i] = d[28 + i];
                else if (hits[i]) m_ip[i] = 1;
                if (w && bus_addr == 8'(8'h20 + 4 * i)) m_cmp[i] = d & 64'hFFFF;
            end
            if (cw) begin
                m_oneshot = d[13]; m_always = d[12]; m_misc = d & 64'h0F0F_070F;
            end else if (rs || cy) begin
                m_oneshot = 0;
            end
            m_cnt = nc;
        end
    end

    // Per-clock irq comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [3:0] e;
            for (int i = 0; i < 4; i++) e[i] = m_ip[i];
            checks++;
            if (irq !== e) begin
                fails++;
                $display("FAIL R5/R6 irq: actual %h expected %h at %0t", irq, e, $time);
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string req);
        logic [31:0] e;
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1;
        e = 32'(m_read(a));
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s read %h: actual %h expected %h", req, a, bus_rdata, e);
        end
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        // R1: reset state
        rd_chk(8'h00, "R1");
        rd_chk(8'h08, "R1");
        rd_chk(8'h10, "R1");
        rd_chk(8'h20, "R1");
        rd_chk(8'h2C, "R1");
        // R4: compare registers mask upper bits
        wr_reg(8'h20, 32'hABCD_1234);
        rd_chk(8'h20, "R4");
        wr_reg(8'h20, 32'hFFFF_FFFF);
        wr_reg(8'h24, 32'h0000_0014);
        wr_reg(8'h28, 32'h1234_FFFF);
        wr_reg(8'h2C, 32'h0000_FFFF);
        rd_chk(8'h28, "R4");
        // R6: clear pending flags
        wr_reg(8'h00, 32'h0);
        rd_chk(8'h00, "R6");
        idle(2);
        // R2, R5: continuous counting, channel 1 fires at 20
        wr_reg(8'h00, 32'h0000_1000);
        idle(10);
        rd_chk(8'h08, "R2");
        idle(15);
        rd_chk(8'h00, "R5");
        // R6: clear while match persists, re-raised
        wr_reg(8'h00, 32'h0000_0000);
        rd_chk(8'h00, "R6");
        idle(3);
        rd_chk(8'h08, "R2");
        // R3, R9: scale and loads while halted
        wr_reg(8'h00, 32'h0000_0004);
        wr_reg(8'h08, 32'h0001_2345);
        rd_chk(8'h10, "R3");
        wr_reg(8'h10, 32'h0001_ABCD);
        rd_chk(8'h08, "R9");
        wr_reg(8'h00, 32'h0000_000F);
        wr_reg(8'h10, 32'h0000_FFFF);
        rd_chk(8'h08, "R9");
        rd_chk(8'h10, "R3");
        wr_reg(8'h08, 32'hFFFF_FFFF);
        rd_chk(8'h08, "R3");
        // R7: restart on channel 0 match in one-shot
        wr_reg(8'h20, 32'h0000_0005);
        wr_reg(8'h08, 32'h0);
        wr_reg(8'h00, 32'h0000_2200);
        idle(10);
        rd_chk(8'h00, "R7");
        rd_chk(8'h08, "R7");
        wr_reg(8'h00, 32'h0000_1200);
        for (int k = 0; k < 8; k++) rd_chk(8'h08, "R7");
        // R8: carry clears one-shot
        wr_reg(8'h00, 32'h0);
        wr_reg(8'h20, 32'h0000_FFFF);
        wr_reg(8'h08, 32'h7FFF_FFFC);
        wr_reg(8'h00, 32'h0000_2000);
        idle(6);
        rd_chk(8'h00, "R8");
        rd_chk(8'h08, "R8");
        wr_reg(8'h08, 32'h7FFF_FFFD);
        wr_reg(8'h00, 32'h0000_3000);
        idle(5);
        rd_chk(8'h00, "R8");
        rd_chk(8'h08, "R8");
        // R10: unmapped offsets and stored-only bits
        wr_reg(8'h00, 32'h0);
        wr_reg(8'h04, 32'hFFFF_FFFF);
        wr_reg(8'h30, 32'hFFFF_FFFF);
        rd_chk(8'h04, "R10");
        rd_chk(8'h30, "R10");
        rd_chk(8'h08, "R10");
        rd_chk(8'h20, "R10");
        wr_reg(8'h00, 32'h0FFF_CDF0);
        rd_chk(8'h00, "R10");
        idle(3);
        rd_chk(8'h08, "R10");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule